// File: doc/BRIEF.md
# Frame-based separation sequencer

This block schedules one frame of work for an adaptive two-channel separation engine built from a forward array and an update array. It holds no arithmetic. It produces the enables, clears and strobes that tell those arrays when to run. A frame starts on a start pulse and has four phases:

- an initialisation cycle;
- a forward phase that consumes the valid samples of the frame;
- an update phase that runs at the doubled update rate;
- a single-cycle reload that moves the learned update costs into the forward weight bank.

Because the reload comes only at the end of a frame, the forward array always works with the weights learned in the previous frame.

The frame length N is captured when the frame starts. While a frame is in progress, the block ignores start and any change on the length input. The running time index is exposed: it steps from 1 to N−1 in the forward phase, from N to 3N−1 in the update phase, and is 3N in the reload cycle. A completed-frame counter and a busy flag are also exposed. Partial sums are cleared at every frame start. Weights are cleared only on the first frame after reset and persist across frames otherwise.

Top module: `sep_frame_seq`

## Requirements
- R1: After reset the block is idle: busy, all enables, both clears, reload, upd_phase, step and frame_cnt are 0.
- R2: A start seen while idle makes the next cycle the initialisation cycle: sum_clr and busy are 1 for exactly that one cycle of clearing. A captured length below 2 is treated as 2.
- R3: wgt_clr is 1 in the initialisation cycle of the first frame after reset and is 0 in the initialisation cycle of every later frame.
- R4: In the forward phase fwd_en equals sample_valid, and step runs 1 to N−1, advancing only on cycles with sample_valid high. The phase ends after the (N−1)th accepted sample.
- R5: The update phase follows at once and lasts exactly 2N consecutive cycles with upd_en high. In this phase step runs N to 3N−1, one per cycle, and sample_valid has no effect.
- R6: upd_phase is 0 in the first update cycle and inverts on every update cycle. It is 0 whenever upd_en is 0.
- R7: reload is 1 for exactly the one cycle after the last update cycle, with step equal to 3N. In the next cycle busy is 0, and one cycle later step is 0.
- R8: frame_cnt increases by exactly one, becoming visible in the cycle after reload, and changes at no other time.
- R9: While busy, start and changes on frame_len have no effect on the schedule in progress.
- R10: At most one of sum_clr, fwd_en, upd_en and reload is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the update phase advances on every edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch one frame when idle |
| frame_len | input | LEN_W | Frame length N, captured at launch |
| sample_valid | input | 1 | A new input sample is present this cycle |
| busy | output | 1 | A frame is in progress |
| sum_clr | output | 1 | Clear all array partial sums |
| wgt_clr | output | 1 | Clear all weights (first frame only) |
| fwd_en | output | 1 | Forward array advance enable |
| upd_en | output | 1 | Update array enable |
| upd_phase | output | 1 | Even/odd selector for the update elements |
| reload | output | 1 | Copy update costs into the forward weights |
| step | output | LEN_W+2 | Time index within the frame |
| frame_cnt | output | CNT_W | Number of completed frames |

## Verification
The assertions assume that reset is applied before the first frame. They also assume that the length input fits LEN_W, so that 3N fits in the step width; any value of start or sample_valid is allowed in any cycle. The stimulus keeps to these assumptions and draws lengths from a small range that includes the clamped values 0 and 1. It draws sample_valid with several densities, holds start high across whole frames and changes the length input during frames. Directed frames cover the shortest length and a reset in the middle of a run, which must bring weight clearing back.

// File: rtl/sep_seq_pkg.sv
// Shared types for the frame sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sep_seq_pkg;

    // Frame schedule phases, in the order a frame visits them.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_INIT = 3'd1,
        ST_FWD  = 3'd2,
        ST_UPD  = 3'd3,
        ST_LOAD = 3'd4
    } seq_state_t;

endpackage

// File: rtl/sep_seq_step.sv
// Time-index counter for one frame.
// Clears to zero, loads one at the start of the forward phase and
// increments when asked. clr has priority over set1, set1 over inc.
// Assumes the caller never lets the index pass 2**STEP_W-1.
module sep_seq_step #(
    parameter int STEP_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set1,
    input  logic              inc,
    output logic [STEP_W-1:0] step
);

    // Index register with prioritised clear/load/increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    step <= '0;
        else if (clr)  step <= '0;
        else if (set1) step <= STEP_W'(1);
        else if (inc)  step <= step + STEP_W'(1);
    end

endmodule

// File: rtl/sep_seq_ctrl.sv
// Phase state machine of the frame sequencer.
// Captures the frame length at launch (clamped to at least 2) and moves
// IDLE -> INIT -> FWD -> UPD -> LOAD -> IDLE using the time index.
// Assumes LEN_W >= 2 and STEP_W >= LEN_W + 2 so that 3N fits.
module sep_seq_ctrl
    import sep_seq_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int STEP_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              sample_valid,
    input  logic [STEP_W-1:0] step,
    output seq_state_t        state
);

    logic [LEN_W-1:0]  len_q;
    logic [STEP_W-1:0] len_x;
    logic [STEP_W-1:0] fwd_last;
    logic [STEP_W-1:0] upd_last;
    seq_state_t        state_d;

    // Phase end points derived from the captured length.
    always_comb begin
        len_x    = STEP_W'(len_q);
        fwd_last = len_x - STEP_W'(1);
        upd_last = (len_x << 1) + len_x - STEP_W'(1);
    end

    // Next-phase selection.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (start) state_d = ST_INIT;
            ST_INIT: state_d = ST_FWD;
            ST_FWD:  if (sample_valid && step == fwd_last) state_d = ST_UPD;
            ST_UPD:  if (step == upd_last) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Length capture at launch, with the lower clamp.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= LEN_W'(2);
        else if (state == ST_IDLE && start)
            len_q <= (frame_len < LEN_W'(2)) ? LEN_W'(2) : frame_len;
    end

endmodule

// File: rtl/sep_seq_frame.sv
// Update-phase toggle, completed-frame counter and first-frame tracking.
// The toggle is 0 on entry to the update phase and inverts each update
// cycle. The counter and the warm flag advance on the reload cycle.
// Assumes in_upd and at_load are never high together.
module sep_seq_frame #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_upd,
    input  logic             at_load,
    output logic             upd_ph,
    output logic [CNT_W-1:0] frame_cnt,
    output logic             warm
);

    // Even/odd toggle, held at 0 outside the update phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      upd_ph <= 1'b0;
        else if (in_upd) upd_ph <= ~upd_ph;
        else             upd_ph <= 1'b0;
    end

    // Completed-frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       frame_cnt <= '0;
        else if (at_load) frame_cnt <= frame_cnt + CNT_W'(1);
    end

    // Set once a frame has produced weights; stops later weight clears.
    always_ff @(posedge clk) begin
        if (!rst_n)       warm <= 1'b0;
        else if (at_load) warm <= 1'b1;
    end

endmodule

// File: rtl/sep_frame_seq.sv
// Frame sequencer for an adaptive separation engine: launches one frame
// per start, drives the clears, enables, update toggle and reload strobe,
// and counts completed frames. Holds no datapath arithmetic.
// Assumes a reset before first use and frame_len < 2**LEN_W.
module sep_frame_seq
    import sep_seq_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic               sample_valid,
    output logic               busy,
    output logic               sum_clr,
    output logic               wgt_clr,
    output logic               fwd_en,
    output logic               upd_en,
    output logic               upd_phase,
    output logic               reload,
    output logic [LEN_W+1:0]   step,
    output logic [CNT_W-1:0]   frame_cnt
);

    localparam int STEP_W = LEN_W + 2;

    seq_state_t        state;
    logic [STEP_W-1:0] step_q;
    logic              warm;
    logic              ph;

    sep_seq_ctrl #(.LEN_W(LEN_W), .STEP_W(STEP_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .frame_len    (frame_len),
        .sample_valid (sample_valid),
        .step         (step_q),
        .state        (state)
    );

    sep_seq_step #(.STEP_W(STEP_W)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE || state == ST_LOAD),
        .set1  (state == ST_INIT),
        .inc   ((state == ST_FWD && sample_valid) || state == ST_UPD),
        .step  (step_q)
    );

    sep_seq_frame #(.CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_upd    (state == ST_UPD),
        .at_load   (state == ST_LOAD),
        .upd_ph    (ph),
        .frame_cnt (frame_cnt),
        .warm      (warm)
    );

    // Output decode from the phase register.
    always_comb begin
        busy      = (state != ST_IDLE);
        sum_clr   = (state == ST_INIT);
        wgt_clr   = (state == ST_INIT) && !warm;
        fwd_en    = (state == ST_FWD) && sample_valid;
        upd_en    = (state == ST_UPD);
        upd_phase = ph;
        reload    = (state == ST_LOAD);
        step      = step_q;
    end

endmodule

// File: rtl/sep_frame_seq_chk.sv
// Property checker for the frame sequencer, bound to every instance.
// Assumes synchronous active-low reset precedes all checked cycles.
module sep_frame_seq_chk #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sample_valid,
    input logic             busy,
    input logic             sum_clr,
    input logic             wgt_clr,
    input logic             fwd_en,
    input logic             upd_en,
    input logic             upd_phase,
    input logic             reload,
    input logic [LEN_W+1:0] step,
    input logic [CNT_W-1:0] frame_cnt
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(sum_clr || fwd_en || upd_en || reload));

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (sum_clr && busy));

    p_init_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sum_clr |=> (!sum_clr && busy));

    p_wclr_in_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wgt_clr |-> sum_clr);

    p_fwd_needs_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_en |-> sample_valid);

    p_upd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en ##1 upd_en) |-> (step == $past(step) + (LEN_W+2)'(1)));

    p_phase_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_en) |-> !upd_phase);

    p_phase_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en ##1 upd_en) |-> (upd_phase != $past(upd_phase)));

    p_phase_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |-> !upd_phase);

    p_reload_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !busy);

    p_cnt_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (frame_cnt == $past(frame_cnt) + CNT_W'(1)));

    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(frame_cnt));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sum_clr, fwd_en, upd_en, reload}));

endmodule

bind sep_frame_seq sep_frame_seq_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .sample_valid (sample_valid),
    .busy         (busy),
    .sum_clr      (sum_clr),
    .wgt_clr      (wgt_clr),
    .fwd_en       (fwd_en),
    .upd_en       (upd_en),
    .upd_phase    (upd_phase),
    .reload       (reload),
    .step         (step),
    .frame_cnt    (frame_cnt)
);

// File: tb/sep_frame_seq_bench.sv
// Self-checking bench: seeded random frames plus directed corner cases.
module sep_frame_seq_bench;

    localparam int LEN_W = 12;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] frame_len = '0;
    logic             sample_valid = 1'b0;
    logic             busy, sum_clr, wgt_clr, fwd_en, upd_en, upd_phase, reload;
    logic [LEN_W+1:0] step;
    logic [CNT_W-1:0] frame_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit exp_warm = 1'b0;
    bit done = 1'b0;

    sep_frame_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_sep_frame_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .sample_valid(sample_valid), .busy(busy), .sum_clr(sum_clr),
        .wgt_clr(wgt_clr), .fwd_en(fwd_en), .upd_en(upd_en),
        .upd_phase(upd_phase), .reload(reload), .step(step),
        .frame_cnt(frame_cnt)
    );

    always #10 clk = ~clk;

    // Advance one clock; act 5 ns after the rising edge.
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_len(input int n);
        return (n < 2) ? 2 : n;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; sample_valid = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        exp_cnt = 0; exp_warm = 1'b0;
        #1;
        chk("R1 busy", busy, 0);
        chk("R1 sum_clr", sum_clr, 0);
        chk("R1 wgt_clr", wgt_clr, 0);
        chk("R1 fwd_en", fwd_en, 0);
        chk("R1 upd_en", upd_en, 0);
        chk("R1 reload", reload, 0);
        chk("R1 upd_phase", upd_phase, 0);
        chk("R1 step", int'(step), 0);
        chk("R1 frame_cnt", int'(frame_cnt), 0);
        tick();
    endtask

    // Run one frame and compare every cycle against the schedule.
    task automatic run_frame(input int n, input bit hold_start, input int vprob);
        int ne;
        int k;
        bit v;
        ne = eff_len(n);
        start = 1'b1; frame_len = LEN_W'(n);
        tick();
        start = hold_start;
        #1;
        chk("R2 sum_clr", sum_clr, 1);
        chk("R2 busy", busy, 1);
        chk("R3 wgt_clr", wgt_clr, exp_warm ? 0 : 1);
        chk("R10 fwd_en in init", fwd_en, 0);
        tick();
        chk("R2 sum_clr single", sum_clr, 0);
        k = 1;
        while (k < ne) begin
            v = (($urandom % 100) < vprob);
            sample_valid = v;
            frame_len = LEN_W'($urandom);   // R9: must not matter
            #1;
            chk("R4 fwd_en", fwd_en, v);
            chk("R4 step", int'(step), k);
            chk("R10 upd_en in fwd", upd_en, 0);
            chk("R6 phase quiet", upd_phase, 0);
            chk("R9 busy", busy, 1);
            tick();
            if (v) k++;
        end
        for (int i = 0; i < 2 * ne; i++) begin
            sample_valid = $urandom % 2;    // R5: no effect
            #1;
            chk("R5 upd_en", upd_en, 1);
            chk("R5 step", int'(step), ne + i);
            chk("R5 fwd_en", fwd_en, 0);
            chk("R6 upd_phase", upd_phase, i % 2);
            tick();
        end
        start = 1'b0; sample_valid = 1'b0;
        #1;
        chk("R7 reload", reload, 1);
        chk("R7 step", int'(step), 3 * ne);
        chk("R7 upd_en", upd_en, 0);
        chk("R8 count before", int'(frame_cnt), exp_cnt);
        tick();
        exp_cnt++; exp_warm = 1'b1;
        chk("R7 busy", busy, 0);
        chk("R7 reload single", reload, 0);
        chk("R8 frame_cnt", int'(frame_cnt), exp_cnt);
        tick();
        chk("R7 step idle", int'(step), 0);
        chk("R9 stays idle", busy, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        // Idle without start: nothing happens.
        for (int i = 0; i < 3; i++) begin
            sample_valid = 1'b1;
            tick();
            chk("R1 idle busy", busy, 0);
            chk("R1 idle fwd_en", fwd_en, 0);
        end
        sample_valid = 1'b0;
        run_frame(2, 1'b0, 100);
        run_frame(0, 1'b0, 100);
        run_frame(1, 1'b1, 60);
        run_frame(5, 1'b1, 30);
        for (int f = 0; f < 12; f++)
            run_frame(2 + int'($urandom % 39), 1'($urandom % 2), 20 + int'($urandom % 81));
        do_reset();
        run_frame(3, 1'b0, 50);
        run_frame(7, 1'b1, 90);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule